// File: doc/BRIEF.md
# Erased Sector Zero-Bit Detector

This block decides whether a sector that the error decoder could not repair is really a freshly erased page with a handful of stray programmed bits. An erased NAND page reads back as all-ones. The check bytes of an erased page are all-ones too, and they do not form a valid codeword for all-ones data, so the decoder reports an uncorrectable sector. The block takes the sector as a byte stream: 512 data bytes followed by 13 check bytes. It counts the bits that read as zero. If the total is within the correction capability, it tells downstream logic to replace the data with all-ones.

A `start` pulse opens a scan and samples the decoder's error count. The scan is armed only when that count is above the correction capability of 8. Accepted bytes are routed by position. The first 512 go to a data tally and the next 13 go to a check tally. Each tally stops growing as soon as it passes 8 and holds at 9. After the byte flagged `in_last` has been accepted, the block raises `done`. With `done` it presents the verdict `erased` and the combined zero-bit count.

Top module: `erased_sector_detector`

## Requirements
- R1: After reset, `done`, `erased` and `zero_count` are all 0.
- R2: A `start` pulse clears both tallies and the done flag. In the cycle after `start`, `done` = 0 and `zero_count` = 0. A byte offered in the same cycle as `start` is not counted.
- R3: The scan is armed only if `dec_err_cnt` sampled with `start` is greater than 8. When the scan is not armed, bytes are not counted. `done` still rises, with `erased` = 0 and `zero_count` = 0.
- R4: The zero-bit count of a byte is the number of its bits equal to 0, which is the popcount of the inverted byte (0x0F contributes 4 and 0xFF contributes 0).
- R5: Of the accepted bytes since `start`, positions 0..511 feed the data tally and positions 512..524 feed the check tally. Bytes at position 525 and beyond are not counted. Each tally saturates at 9 once its running total exceeds 8.
- R6: A byte is accepted only while a scan is open and `in_valid` = 1; `in_last` is ignored while `in_valid` = 0. `done` rises in the cycle after the accepted byte with `in_last` = 1. It stays high until the next `start`, and bytes offered after it are ignored.
- R7: `erased` = 1 exactly when `done` = 1, the scan is armed, and the data tally plus the check tally is 8 or less.
- R8: `zero_count` equals the data tally plus the check tally, with each tally saturated, so its largest value is 18.
- R9: An all-0xFF sector on an armed scan ends with `erased` = 1 and `zero_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a new scan and clears the results |
| dec_err_cnt | input | 4 | Decoder error count for the sector, sampled with `start` |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Sector byte |
| in_last | input | 1 | Marks the final byte of the sector |
| done | output | 1 | Scan complete, held until the next `start` |
| erased | output | 1 | Sector is erased, so its data is to be filled with all-ones |
| zero_count | output | 5 | Sum of the saturated data and check zero tallies |

## Verification
The all-ones sector checks the zero result and the erased verdict. A sector with exactly 8 zeros split across data and check sits on the boundary of the verdict, and a sector with 9 zeros sits one step past it. A data region full of 0x00 shows that the data tally saturates on its own while the check tally keeps counting. A zero-heavy byte placed at position 512 shows that the region boundary falls in the right place, and a 526th byte shows that trailing bytes are dropped. Separate runs cover idle cycles carrying 0x00 and a stray `in_last`, a decoder error count of 8 that leaves the scan unarmed, and bytes offered after `done`.

// File: rtl/ezd_pkg.sv
package ezd_pkg;

  // Number of bits that read as zero in one byte.
  function automatic logic [3:0] zero_bits(input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int k = 0; k < 8; k++) n = n + {3'b000, ~b[k]};
    return n;
  endfunction

  // Running total that stops growing once it passes lim and holds at lim+1.
  function automatic int sat_add(input int cur, input int inc, input int lim);
    return (cur + inc > lim) ? lim + 1 : cur + inc;
  endfunction

endpackage

// File: rtl/ezd_region_tracker.sv
module ezd_region_tracker #(
  parameter int DATA_BYTES  = 512,
  parameter int CHECK_BYTES = 13,
  localparam int TOTAL      = DATA_BYTES + CHECK_BYTES,
  localparam int POS_W      = $clog2(TOTAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  output logic take_data,
  output logic take_check,
  output logic last_seen
);

  logic             running;
  logic [POS_W-1:0] pos;
  logic             accept;

  assign accept     = running && in_valid && !start;
  assign take_data  = accept && (int'(pos) < DATA_BYTES);
  assign take_check = accept && (int'(pos) >= DATA_BYTES) && (int'(pos) < TOTAL);
  assign last_seen  = accept && in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pos     <= '0;
    end else if (start) begin
      running <= 1'b1;
      pos     <= '0;
    end else if (accept) begin
      if (in_last) running <= 1'b0;
      if (pos != POS_W'(TOTAL)) pos <= pos + 1'b1;
    end
  end

  // A byte lands in at most one region.
  assert_one_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_data && take_check));

  // Once the last byte is taken, nothing more is routed until a new start.
  assert_quiet_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_seen && !start) |=> !(take_data || take_check || last_seen));

endmodule

// File: rtl/ezd_zero_tally.sv
module ezd_zero_tally #(
  parameter int LIMIT   = 8,
  localparam int CNT_W  = $clog2(LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [7:0]       din,
  output logic [CNT_W-1:0] tally
);
  import ezd_pkg::*;

  localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT + 1);

  logic [CNT_W-1:0] next_tally;
  assign next_tally = CNT_W'(sat_add(int'(tally), int'(zero_bits(din)), LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tally <= '0;
    else if (clr) tally <= '0;
    else if (en)  tally <= next_tally;
  end

  assert_tally_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tally <= SAT);

  assert_tally_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tally == SAT && !clr) |=> tally == SAT);

  assert_tally_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(tally));

endmodule

// File: rtl/erased_sector_detector.sv
module erased_sector_detector #(
  parameter int DATA_BYTES  = 512,
  parameter int CHECK_BYTES = 13,
  parameter int LIMIT       = 8,
  parameter int ERR_W       = 4,
  localparam int CNT_W      = $clog2(LIMIT + 2),
  localparam int SUM_W      = $clog2(2 * LIMIT + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ERR_W-1:0] dec_err_cnt,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             done,
  output logic             erased,
  output logic [SUM_W-1:0] zero_count
);

  logic             take_data, take_check, last_seen;
  logic             armed;
  logic [1:0]       take;
  logic [CNT_W-1:0] tally [2];

  ezd_region_tracker #(
    .DATA_BYTES (DATA_BYTES),
    .CHECK_BYTES(CHECK_BYTES)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .take_data (take_data),
    .take_check(take_check),
    .last_seen (last_seen)
  );

  assign take = {take_check, take_data};

  for (genvar g = 0; g < 2; g++) begin : g_tally
    ezd_zero_tally #(.LIMIT(LIMIT)) u_tally (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start),
      .en   (take[g] && armed),
      .din  (in_byte),
      .tally(tally[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      armed <= int'(dec_err_cnt) > LIMIT;
      done  <= 1'b0;
    end else if (last_seen) begin
      done  <= 1'b1;
    end
  end

  assign zero_count = SUM_W'(tally[0]) + SUM_W'(tally[1]);
  assign erased     = done && armed && (int'(zero_count) <= LIMIT);

  assert_erased_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erased |-> done);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && zero_count == '0));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_unarmed_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> zero_count == '0);

  assert_sum_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zero_count) <= 2 * (LIMIT + 1));

endmodule

// File: tb/erased_sector_detector_tb.sv
module erased_sector_detector_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] dec_err_cnt = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'hFF;
  logic       in_last = 1'b0;
  logic       done, erased;
  logic [4:0] zero_count;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] sec [0:525];

  always #10ns clk = ~clk;

  erased_sector_detector u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_err_cnt(dec_err_cnt),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .done(done), .erased(erased), .zero_count(zero_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_ones();
    for (int i = 0; i < 526; i++) sec[i] = 8'hFF;
  endtask

  // Independent model: walk the bits, stop each region once it passes 8.
  task automatic model(input int n, input bit arm, output int cnt, output bit ers);
    int d, c;
    d = 0; c = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (sec[i][k] == 1'b0) begin
          if (i < 512 && d <= 8) d++;
          else if (i >= 512 && i < 525 && c <= 8) c++;
        end
      end
    end
    cnt = arm ? d + c : 0;
    ers = arm && (d + c <= 8);
  endtask

  task automatic do_start(input int err);
    start = 1'b1; dec_err_cnt = 4'(err);
    in_valid = 1'b1; in_byte = 8'h00;   // offered with start: must be ignored
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk("R2 done cleared", done, 0);
    chk("R2 count cleared", zero_count, 0);
  endtask

  task automatic stream(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b1;
        @(negedge clk);
      end
      in_valid = 1'b1; in_byte = sec[i]; in_last = (i == n - 1);
      if (i == n - 1) chk("R6 done low on last byte", done, 0);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_byte = 8'hFF;
  endtask

  task automatic run(input string tag, input int err, input int n, input bit gaps);
    int ecnt; bit eers;
    do_start(err);
    stream(n, gaps);
    model(n, err > 8, ecnt, eers);
    chk({tag, " done"}, done, 1);
    chk({tag, " erased"}, erased, int'(eers));
    chk({tag, " count"}, zero_count, ecnt);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 erased", erased, 0);
    chk("R1 count", zero_count, 0);
  endtask

  task automatic t_all_ones();
    fill_ones();
    run("R9 all-ones", 12, 525, 1'b0);
    chk("R9 erased", erased, 1);
    chk("R9 count", zero_count, 0);
  endtask

  task automatic t_eight_split();
    fill_ones();
    sec[40] = 8'h0F; sec[300] = 8'hFE;     // R4: 4 + 1 data zeros
    sec[513] = 8'hF8;                       // 3 check zeros
    run("R7 eight", 9, 525, 1'b0);
    chk("R7 eight erased", erased, 1);
    chk("R4 count", zero_count, 8);
  endtask

  task automatic t_nine();
    fill_ones();
    sec[0] = 8'h00; sec[524] = 8'hBF;
    run("R7 nine", 15, 525, 1'b0);
    chk("R7 nine erased", erased, 0);
    chk("R8 nine count", zero_count, 9);
  endtask

  task automatic t_saturate();
    fill_ones();
    for (int i = 0; i < 512; i++) sec[i] = 8'h00;
    sec[520] = 8'hFC;
    run("R5 saturate", 10, 525, 1'b0);
    chk("R5 data saturates", zero_count, 11);
    for (int i = 512; i < 525; i++) sec[i] = 8'h00;
    run("R8 max", 10, 525, 1'b0);
    chk("R8 max count", zero_count, 18);
  endtask

  task automatic t_boundary();
    fill_ones();
    sec[511] = 8'h7F; sec[512] = 8'h00; sec[525] = 8'h00;
    run("R5 boundary", 11, 526, 1'b0);
    chk("R5 tail ignored", zero_count, 9);
    fill_ones();
    sec[525] = 8'h00;
    run("R5 only tail", 11, 526, 1'b0);
    chk("R5 tail erased", erased, 1);
  endtask

  task automatic t_gaps();
    fill_ones();
    sec[5] = 8'hEF; sec[518] = 8'hFC;
    run("R6 gaps", 13, 525, 1'b1);
    chk("R6 gaps count", zero_count, 3);
  endtask

  task automatic t_unarmed();
    fill_ones();
    sec[3] = 8'h0F;
    run("R3 unarmed", 8, 525, 1'b0);
    chk("R3 erased", erased, 0);
    chk("R3 count", zero_count, 0);
  endtask

  task automatic t_after_done();
    fill_ones();
    sec[7] = 8'hFE;
    run("R6 pre", 12, 525, 1'b0);
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_byte = 8'h00; in_last = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk("R6 done held", done, 1);
    chk("R6 late bytes ignored", zero_count, 1);
    chk("R7 still erased", erased, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'h00; in_last = 1'b1;   // no scan open yet
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R6 no scan no done", done, 0);
    t_all_ones();
    t_eight_split();
    t_nine();
    t_saturate();
    t_boundary();
    t_gaps();
    t_unarmed();
    t_after_done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule